// File: doc/BRIEF.md
# Data Cache Maintenance Sequencer

This unit carries out maintenance commands on a two-way, 64-set data cache whose tag and data arrays sit outside it. A command carries a 5-bit operation code, a 32-bit effective address and a 32-bit tag-low register value. The unit either looks the address up in both ways (hit-addressed commands) or takes the set and way straight from address bits (index-addressed commands). It then reads or rewrites the selected tag word or data word, and it can return a data word or the tag flags through the tag-low result.

The unit sees each tag word as a 20-bit line address in bits 31:12 and a 12-bit flag field in bits 11:0. When a command must flush a dirty line first, the unit raises a write-back request that carries the line address and holds it until memory acknowledges. Only then does it update the arrays and finish the command. Instruction-cache and branch-target flush codes are accepted and do nothing. Any code the unit does not know finishes with a one-cycle unsupported flag.

Top module: `cache_maint_unit`

## Requirements
- R1: After reset, done_o, unsupported_o and wb_req_o are 0, taglo_o is 0 and cmd_ready_o is 1.
- R2: A tag word holds a line address in bits 31:12, dirty at bit 6, valid at bit 5, least-recently-filled at bit 4 and lock at bit 3. A hit-addressed command hits a way when that way's valid bit is set and its bits 31:12 equal addr_i[31:12]. Way 0 wins when both ways hit.
- R3: Code 0x1A, on a hit, rewrites the hit tag so that only its bit 4 survives and every other bit is 0. It makes no write-back request.
- R4: Codes 0x18 and 0x1C, on a hit whose tag has dirty and valid both set, raise wb_req_o with wb_addr_o = {tag[31:12], set, 6'b0} and hold it until wb_ack_i. After that, 0x18 clears the tag as in R3, and 0x1C only clears the dirty bit. If the hit line is not dirty, 0x18 clears it without a write-back and 0x1C leaves it unchanged.
- R5: A hit-addressed code (0x1A, 0x18, 0x1C) that misses in both ways changes no tag and no data word and makes no write-back request.
- R6: Index-addressed codes select the set from addr_i[11:6] and the way from addr_i[0]. Code 0x16 clears the selected tag as in R3 without a write-back. Code 0x14 first writes back if the tag is dirty and valid, then clears it.
- R7: Code 0x11 returns on taglo_o the data word selected by addr_i[5:2] in the indexed line. Code 0x13 writes taglo_i into that word.
- R8: Code 0x10 first writes back if the indexed tag is dirty and valid, then returns {20'b0, flags} on taglo_o. The flags are read after any write-back, so the dirty bit shows 0 once a write-back has happened.
- R9: Code 0x12 replaces bits 11:0 of the indexed tag with taglo_i[11:0] and keeps bits 31:12.
- R10: Codes 0x07 and 0x0C finish with no array change and unsupported_o low. Every other code outside 0x10-0x14, 0x16, 0x18, 0x1A and 0x1C finishes with no array change and with unsupported_o high together with done_o.
- R11: Each accepted command raises done_o for exactly one cycle. A command that needs a write-back raises done_o only after wb_ack_i has been seen. taglo_o keeps its value across commands that do not load it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Unit idle, command accepted this cycle if valid |
| op_i | input | 5 | Operation code |
| addr_i | input | 32 | Effective address |
| taglo_i | input | 32 | Tag-low register value |
| taglo_o | output | 32 | Tag-low result |
| done_o | output | 1 | Command finished (one cycle) |
| unsupported_o | output | 1 | Unknown code, valid with done_o |
| arr_set_o | output | 6 | Set index to the arrays |
| arr_way_o | output | 1 | Way selected for read and write |
| arr_word_o | output | 4 | Data word within the line |
| tag0_i | input | 32 | Tag word of way 0 at arr_set_o |
| tag1_i | input | 32 | Tag word of way 1 at arr_set_o |
| data_rd_i | input | 32 | Data word at arr_set_o/arr_way_o/arr_word_o |
| tag_we_o | output | 1 | Tag write enable |
| tag_wdata_o | output | 32 | Tag write value |
| data_we_o | output | 1 | Data word write enable |
| data_wdata_o | output | 32 | Data word write value |
| wb_req_o | output | 1 | Write-back request, held until acknowledged |
| wb_addr_o | output | 32 | Line address of the write-back |
| wb_ack_i | input | 1 | Write-back acknowledge |

## Verification
The bench builds the unit with its default widths: 32-bit addresses, 6 set bits, 6 offset bits and a 12-bit flag field. Random traffic stays in sets 0 to 7 and uses only four line-address values, so hits in way 0, hits in way 1, double hits and misses all occur often. Random flag fields make dirty, valid and least-recently-filled combinations common. The memory acknowledge comes after a random delay of 0 to 3 cycles, so the wait for a write-back is exercised over several lengths.

// File: rtl/cmu_pkg.sv
package cmu_pkg;
  localparam logic [4:0] OP_HIT_INV    = 5'h1A;
  localparam logic [4:0] OP_HIT_WBINV  = 5'h18;
  localparam logic [4:0] OP_HIT_WB     = 5'h1C;
  localparam logic [4:0] OP_IDX_INV    = 5'h16;
  localparam logic [4:0] OP_IDX_WBINV  = 5'h14;
  localparam logic [4:0] OP_IDX_LDWORD = 5'h11;
  localparam logic [4:0] OP_IDX_STWORD = 5'h13;
  localparam logic [4:0] OP_IDX_LDFLAG = 5'h10;
  localparam logic [4:0] OP_IDX_STFLAG = 5'h12;
  localparam logic [4:0] OP_ICACHE_NOP = 5'h07;
  localparam logic [4:0] OP_BRTGT_NOP  = 5'h0C;

  localparam int FLAG_W    = 12;
  localparam int DIRTY_BIT = 6;
  localparam int VALID_BIT = 5;
  localparam int LRF_BIT   = 4;

  typedef struct packed {
    logic hit_mode;
    logic do_wb;
    logic do_clear;
    logic ld_word;
    logic st_word;
    logic ld_flags;
    logic st_flags;
    logic unsup;
  } cmu_dec_t;

  typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_WB} cmu_state_e;
endpackage

// File: rtl/cmu_decode.sv
module cmu_decode
  import cmu_pkg::*;
(
  input  logic [4:0] op_i,
  output cmu_dec_t   dec_o
);
  always_comb begin
    dec_o = '0;
    unique case (op_i)
      OP_HIT_INV:    begin dec_o.hit_mode = 1'b1; dec_o.do_clear = 1'b1; end
      OP_HIT_WBINV:  begin dec_o.hit_mode = 1'b1; dec_o.do_wb = 1'b1; dec_o.do_clear = 1'b1; end
      OP_HIT_WB:     begin dec_o.hit_mode = 1'b1; dec_o.do_wb = 1'b1; end
      OP_IDX_INV:    dec_o.do_clear = 1'b1;
      OP_IDX_WBINV:  begin dec_o.do_wb = 1'b1; dec_o.do_clear = 1'b1; end
      OP_IDX_LDWORD: dec_o.ld_word = 1'b1;
      OP_IDX_STWORD: dec_o.st_word = 1'b1;
      OP_IDX_LDFLAG: begin dec_o.do_wb = 1'b1; dec_o.ld_flags = 1'b1; end
      OP_IDX_STFLAG: dec_o.st_flags = 1'b1;
      OP_ICACHE_NOP, OP_BRTGT_NOP: ;
      default:       dec_o.unsup = 1'b1;
    endcase
  end
endmodule

// File: rtl/cmu_lookup.sv
module cmu_lookup
  import cmu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WAYS   = 2,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [WAYS-1:0][ADDR_W-1:0] tags_i,
  output logic                        hit_o,
  output logic [WAY_W-1:0]            hit_way_o
);
  logic [WAYS-1:0] way_hit;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign way_hit[w] = tags_i[w][VALID_BIT] &&
                        (tags_i[w][ADDR_W-1:FLAG_W] == addr_i[ADDR_W-1:FLAG_W]);
  end

  // lowest way wins
  always_comb begin
    hit_way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (way_hit[w]) hit_way_o = WAY_W'(w);
    end
  end

  assign hit_o = |way_hit;
endmodule

// File: rtl/cache_maint_unit.sv
module cache_maint_unit
  import cmu_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SET_W   = 6,
  parameter int OFF_W   = 6,
  localparam int WORD_W = OFF_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [4:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       taglo_i,
  output logic [31:0]       taglo_o,
  output logic              done_o,
  output logic              unsupported_o,
  output logic [SET_W-1:0]  arr_set_o,
  output logic              arr_way_o,
  output logic [WORD_W-1:0] arr_word_o,
  input  logic [ADDR_W-1:0] tag0_i,
  input  logic [ADDR_W-1:0] tag1_i,
  input  logic [31:0]       data_rd_i,
  output logic              tag_we_o,
  output logic [ADDR_W-1:0] tag_wdata_o,
  output logic              data_we_o,
  output logic [31:0]       data_wdata_o,
  output logic              wb_req_o,
  output logic [ADDR_W-1:0] wb_addr_o,
  input  logic              wb_ack_i
);
  cmu_state_e        state_q, state_d;
  logic [4:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [31:0]       taglo_in_q;
  logic              done_q, unsup_q;
  logic [31:0]       taglo_q;

  cmu_dec_t          dec;
  logic              hit, hit_way, sel_way, active, dirty_valid, need_wb, act, did_wb;
  logic [ADDR_W-1:0] sel_tag;
  logic [FLAG_W-1:0] flags_now;

  cmu_decode u_dec (.op_i(op_q), .dec_o(dec));

  cmu_lookup #(.ADDR_W(ADDR_W), .WAYS(2)) u_lookup (
    .addr_i   (addr_q),
    .tags_i   ({tag1_i, tag0_i}),
    .hit_o    (hit),
    .hit_way_o(hit_way)
  );

  assign sel_way     = dec.hit_mode ? hit_way : addr_q[0];
  assign sel_tag     = sel_way ? tag1_i : tag0_i;
  assign active      = dec.hit_mode ? hit : !dec.unsup;
  assign dirty_valid = sel_tag[DIRTY_BIT] && sel_tag[VALID_BIT];
  assign need_wb     = (state_q == ST_EXEC) && active && dec.do_wb && dirty_valid;
  assign did_wb      = (state_q == ST_WB);
  assign act         = ((state_q == ST_EXEC) && !need_wb) || (did_wb && wb_ack_i);

  assign arr_set_o  = addr_q[OFF_W +: SET_W];
  assign arr_way_o  = sel_way;
  assign arr_word_o = addr_q[2 +: WORD_W];

  assign wb_req_o  = did_wb;
  assign wb_addr_o = {sel_tag[ADDR_W-1:FLAG_W], addr_q[FLAG_W-1:OFF_W], OFF_W'(0)};

  // flags as seen after a completed write-back
  always_comb begin
    flags_now = sel_tag[FLAG_W-1:0];
    if (did_wb) flags_now[DIRTY_BIT] = 1'b0;
  end

  always_comb begin
    tag_we_o    = 1'b0;
    tag_wdata_o = sel_tag;
    if (act && active) begin
      if (dec.do_clear) begin
        tag_we_o    = 1'b1;
        tag_wdata_o = '0;
        tag_wdata_o[LRF_BIT] = sel_tag[LRF_BIT];
      end else if (dec.st_flags) begin
        tag_we_o    = 1'b1;
        tag_wdata_o = {sel_tag[ADDR_W-1:FLAG_W], taglo_in_q[FLAG_W-1:0]};
      end else if (did_wb) begin
        tag_we_o    = 1'b1;
        tag_wdata_o = {sel_tag[ADDR_W-1:FLAG_W], flags_now};
      end
    end
  end

  assign data_we_o    = act && dec.st_word;
  assign data_wdata_o = taglo_in_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (cmd_valid_i) state_d = ST_EXEC;
      ST_EXEC: state_d = need_wb ? ST_WB : ST_IDLE;
      ST_WB:   if (wb_ack_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      op_q       <= '0;
      addr_q     <= '0;
      taglo_in_q <= '0;
      done_q     <= 1'b0;
      unsup_q    <= 1'b0;
      taglo_q    <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= act;
      unsup_q <= act && dec.unsup;
      if (state_q == ST_IDLE && cmd_valid_i) begin
        op_q       <= op_i;
        addr_q     <= addr_i;
        taglo_in_q <= taglo_i;
      end
      if (act && dec.ld_word)  taglo_q <= data_rd_i;
      if (act && dec.ld_flags) taglo_q <= {{(32-FLAG_W){1'b0}}, flags_now};
    end
  end

  assign cmd_ready_o   = (state_q == ST_IDLE);
  assign done_o        = done_q;
  assign unsupported_o = unsup_q;
  assign taglo_o       = taglo_q;

  a_r11_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r4_wb_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_req_o && !wb_ack_i) |=> (wb_req_o && $stable(wb_addr_o)));
  a_r4_wb_only_dirty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_req_o |-> (sel_tag[DIRTY_BIT] && sel_tag[VALID_BIT]));
  a_r11_done_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wb_req_o) |-> done_o);
  a_r10_unsup_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unsupported_o |-> done_o);
  a_r5_no_write_on_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec.hit_mode && !hit) |-> (!tag_we_o && !wb_req_o));
  a_r11_one_array_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tag_we_o && data_we_o));
endmodule

// File: tb/cache_maint_unit_bench.sv
`timescale 1ns/1ps
module cache_maint_unit_bench;
  localparam int NSETS = 8;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cmd_valid = 1'b0, wb_ack = 1'b0;
  logic [4:0]  op = '0;
  logic [31:0] addr = '0, taglo_in = '0;
  logic        cmd_ready, done, unsup, arr_way, tag_we, data_we, wb_req;
  logic [5:0]  arr_set;
  logic [3:0]  arr_word;
  logic [31:0] taglo_out, tag0, tag1, data_rd, tag_wdata, data_wdata, wb_addr;

  logic [31:0] env_tag [2][64];
  logic [31:0] env_dat [2][64][16];
  logic [31:0] ref_tag [2][64];
  logic [31:0] ref_dat [2][64][16];

  logic        poke_t = 1'b0, poke_d = 1'b0, poke_w = 1'b0;
  logic [5:0]  poke_s = '0;
  logic [3:0]  poke_i = '0;
  logic [31:0] poke_v = '0;

  int n_chk = 0, n_fail = 0, n_wb = 0;
  logic [31:0] last_wb_addr = '0;
  logic [31:0] exp_taglo = '0;

  always #4 clk = ~clk;

  cache_maint_unit u_cache_maint_unit (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .op_i(op), .addr_i(addr), .taglo_i(taglo_in), .taglo_o(taglo_out),
    .done_o(done), .unsupported_o(unsup), .arr_set_o(arr_set), .arr_way_o(arr_way),
    .arr_word_o(arr_word), .tag0_i(tag0), .tag1_i(tag1), .data_rd_i(data_rd),
    .tag_we_o(tag_we), .tag_wdata_o(tag_wdata), .data_we_o(data_we),
    .data_wdata_o(data_wdata), .wb_req_o(wb_req), .wb_addr_o(wb_addr), .wb_ack_i(wb_ack)
  );

  assign tag0    = env_tag[0][arr_set];
  assign tag1    = env_tag[1][arr_set];
  assign data_rd = env_dat[arr_way][arr_set][arr_word];

  // array storage seen by the unit
  always @(posedge clk) begin
    if (poke_t) env_tag[poke_w][poke_s] <= poke_v;
    else if (poke_d) env_dat[poke_w][poke_s][poke_i] <= poke_v;
    else begin
      if (tag_we) env_tag[arr_way][arr_set] <= tag_wdata;
      if (data_we) env_dat[arr_way][arr_set][arr_word] <= data_wdata;
    end
  end

  // memory side: acknowledge after 0..3 cycles
  initial begin
    forever begin
      @(negedge clk);
      if (wb_req && !wb_ack) begin
        for (int d = $urandom_range(0, 3); d > 0; d--) @(negedge clk);
        last_wb_addr = wb_addr;
        n_wb++;
        wb_ack = 1'b1;
        @(negedge clk);
        wb_ack = 1'b0;
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic poke_tag(int w, int s, logic [31:0] v);
    @(negedge clk);
    poke_t = 1'b1; poke_w = w[0]; poke_s = s[5:0]; poke_v = v;
    ref_tag[w][s] = v;
    @(negedge clk);
    poke_t = 1'b0;
  endtask

  task automatic poke_dat(int w, int s, int i, logic [31:0] v);
    @(negedge clk);
    poke_d = 1'b1; poke_w = w[0]; poke_s = s[5:0]; poke_i = i[3:0]; poke_v = v;
    ref_dat[w][s][i] = v;
    @(negedge clk);
    poke_d = 1'b0;
  endtask

  function automatic string req_of(logic [4:0] o);
    case (o)
      5'h1A: return "R3";
      5'h18, 5'h1C: return "R4";
      5'h16, 5'h14: return "R6";
      5'h11, 5'h13: return "R7";
      5'h10: return "R8";
      5'h12: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic run_cmd(logic [4:0] o, logic [31:0] a, logic [31:0] tl);
    int s, w, wd, tmo;
    logic hit, ewb, eun, saw_done;
    logic [31:0] t, ewa;
    string rq;
    s = int'(a[11:6]); wd = int'(a[5:2]); rq = req_of(o);
    hit = 1'b0; w = int'(a[0]);
    if (o == 5'h1A || o == 5'h18 || o == 5'h1C) begin
      if (ref_tag[0][s][5] && ref_tag[0][s][31:12] == a[31:12]) begin hit = 1'b1; w = 0; end
      else if (ref_tag[1][s][5] && ref_tag[1][s][31:12] == a[31:12]) begin hit = 1'b1; w = 1; end
      if (!hit) rq = "R5";
    end else hit = 1'b1;
    t = ref_tag[w][s];
    ewb = 1'b0; eun = 1'b0; ewa = {t[31:12], a[11:6], 6'b0};
    case (o)
      5'h1A, 5'h16: if (hit) ref_tag[w][s] = t & 32'h10;
      5'h18, 5'h14: if (hit) begin ewb = t[6] & t[5]; ref_tag[w][s] = t & 32'h10; end
      5'h1C: if (hit && t[6] && t[5]) begin ewb = 1'b1; ref_tag[w][s] = t & ~32'h40; end
      5'h10: begin
        if (t[6] && t[5]) begin ewb = 1'b1; ref_tag[w][s] = t & ~32'h40; end
        exp_taglo = {20'b0, ref_tag[w][s][11:0]};
      end
      5'h11: exp_taglo = ref_dat[w][s][wd];
      5'h13: ref_dat[w][s][wd] = tl;
      5'h12: ref_tag[w][s] = {t[31:12], tl[11:0]};
      5'h07, 5'h0C: ;
      default: eun = 1'b1;
    endcase
    n_wb = 0;
    @(negedge clk);
    check("R11 ready", {31'b0, cmd_ready}, 32'd1);
    cmd_valid = 1'b1; op = o; addr = a; taglo_in = tl;
    @(negedge clk);
    cmd_valid = 1'b0;
    saw_done = 1'b0;
    for (tmo = 0; tmo < 40 && !saw_done; tmo++) begin
      if (done) saw_done = 1'b1; else @(negedge clk);
    end
    check({"R11 done ", rq}, {31'b0, saw_done}, 32'd1);
    check({"R11 wb before done ", rq}, n_wb, {31'b0, ewb});
    if (ewb) check({rq, " wb addr"}, last_wb_addr, ewa);
    check({"R10 unsupported ", rq}, {31'b0, unsup}, {31'b0, eun});
    check({rq, " taglo"}, taglo_out, exp_taglo);
    check({rq, " tag way0"}, env_tag[0][s], ref_tag[0][s]);
    check({rq, " tag way1"}, env_tag[1][s], ref_tag[1][s]);
    check({rq, " data word"}, env_dat[w][s][wd], ref_dat[w][s][wd]);
    @(negedge clk);
    check("R11 single done", {31'b0, done}, 32'd0);
  endtask

  function automatic logic [31:0] rnd_tag();
    return {18'b0, 2'($urandom_range(0, 3)), 12'($urandom & 32'h78)};
  endfunction

  initial begin
    void'($urandom(32'd7121));
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 64; s++) begin
        ref_tag[w][s] = '0;
        env_tag[w][s] = '0;
        for (int i = 0; i < 16; i++) begin ref_dat[w][s][i] = '0; env_dat[w][s][i] = '0; end
      end
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 done", {31'b0, done}, 32'd0);
    check("R1 unsupported", {31'b0, unsup}, 32'd0);
    check("R1 wb_req", {31'b0, wb_req}, 32'd0);
    check("R1 taglo", taglo_out, 32'd0);
    check("R1 ready", {31'b0, cmd_ready}, 32'd1);
    rst_n = 1'b1;
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < NSETS; s++) begin
        poke_tag(w, s, rnd_tag());
        for (int i = 0; i < 16; i++) poke_dat(w, s, i, $urandom);
      end
    // directed: R2 both ways hit, way 0 chosen; R4 dirty write-back
    poke_tag(0, 5, 32'h0000_1070);
    poke_tag(1, 5, 32'h0000_1060);
    run_cmd(5'h18, 32'h0000_1140, 32'h0);
    check("R2 way1 untouched", env_tag[1][5], 32'h0000_1060);
    run_cmd(5'h1C, 32'h0000_1144, 32'h0);
    check("R4 dirty cleared valid kept", env_tag[1][5], 32'h0000_1020);
    // R5 miss
    run_cmd(5'h1A, 32'h0000_3140, 32'h0);
    // R8 flags after write-back, R9 flags store
    poke_tag(1, 2, 32'h0000_2068);
    run_cmd(5'h10, 32'h0000_0081, 32'h0);
    check("R8 taglo flags", taglo_out, 32'h0000_0028);
    run_cmd(5'h12, 32'h0000_0081, 32'hFFFF_FABC);
    check("R9 address kept", env_tag[1][2], 32'h0000_2ABC);
    // R7 store then load a word
    run_cmd(5'h13, 32'h0000_00FD, 32'hCAFE_F00D);
    run_cmd(5'h11, 32'h0000_00FD, 32'h0);
    check("R7 word roundtrip", taglo_out, 32'hCAFE_F00D);
    // R10 no-ops and unknown code, R11 taglo kept
    run_cmd(5'h07, 32'h0000_00FD, 32'h0);
    run_cmd(5'h0C, 32'h0000_00FD, 32'h0);
    run_cmd(5'h05, 32'h0000_00FD, 32'h0);
    check("R11 taglo kept", taglo_out, 32'hCAFE_F00D);
    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [4:0] ops [14] = '{5'h1A, 5'h18, 5'h1C, 5'h16, 5'h14, 5'h11, 5'h13,
                               5'h10, 5'h12, 5'h07, 5'h0C, 5'h1F, 5'h00, 5'h15};
      logic [4:0] o;
      logic [31:0] a;
      o = ops[$urandom_range(0, 13)];
      a = {18'b0, 2'($urandom_range(0, 3)), 3'b0, 3'($urandom_range(0, NSETS - 1)), 6'($urandom)};
      run_cmd(o, a, $urandom);
      if (($urandom & 7) == 0) poke_tag(int'(a[0]), int'(a[8:6]), rnd_tag());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_chk++;
    n_fail++;
    $display("FAIL R11 watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule